// File: doc/BRIEF.md
# Seven-Slot Multi-Lane Deserializer

This block rebuilds a wide parallel word from a group of serial lanes. The lanes travel next to a forwarded clock lane. Everything runs on one bit clock that is seven times the word rate. In every word period each data lane carries seven bits, sent most significant first. The clock lane repeats a fixed seven-slot shape: high for four slots, then low for three. The block uses the low-to-high step of that shape to find where each period starts. It gathers the seven bits of every lane, then moves the finished word through a staging register into the output register.

In wide mode all four lanes are used, which gives a 28-bit word. In narrow mode only the three lower lanes are used and the upper field of the word reads as zero. Along with the word, a derived output clock is produced. Its rising edge falls inside the window in which the word is stable. An active-low sleep input clears the word and stops the output clock. A line-fault input, which a detector outside this block supplies, freezes the last good word and also stops the output clock. The analog receivers and any clock multiplication are outside the scope of this block.

Top module: `pixdeser_top`

## Requirements
- R1: Within one period, the sample taken in slot 0 of lane k goes to word bit 7k+6, and the sample taken in slot 6 goes to word bit 7k (most significant bit first).
- R2: With narrow_mode=0, the four lanes fill a 28-bit word, and lane k fills bits 7k+6 down to 7k.
- R3: With narrow_mode=1 at the time a period is captured, lane 3 is ignored and bits 27:21 of that word are zero.
- R4: Slot 0 is the bit-clock cycle in which clk_lane_in is 1 and was 0 in the cycle before. The idle clock-lane shape, slots 0 to 6, is 1,1,1,1,0,0,0.
- R5: The block counts as locked after three rising clock-lane steps in a row, each exactly seven cycles after the previous one. While not locked, word_out keeps its value (zero after reset) and word_clk_out stays 0.
- R6: Lock is lost when a rising step comes in any slot other than the expected slot 0, or when no step comes at the expected slot 0. Locking again needs three more steps in a row.
- R7: While locked, a period whose slot 0 is sampled in cycle n appears on word_out from cycle n+14 onward. That is two word periods, and the change takes effect on the edge that samples slot 6 of the next period.
- R8: While locked and running, word_clk_out is 0 in the cycle in which word_out changes and in the two cycles after it, then 1 for four cycles (slots 2 to 5).
- R9: While sleep_n=0, word_out becomes zero and word_clk_out becomes 0 from the next cycle, and lock is cleared.
- R10: While line_fault=1 and sleep_n=1, word_out holds its last value, word_clk_out is 0, and lock is cleared.
- R11: Synchronous active-high reset clears word_out to zero, sets word_clk_out to 0 and clears lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, seven cycles per word period |
| rst | input | 1 | Synchronous reset, active high |
| lane_in | input | 4 | One serial data bit per lane in each bit-clock cycle |
| clk_lane_in | input | 1 | Forwarded clock lane sample (shape 1111000) |
| narrow_mode | input | 1 | 1 = three-lane, 21-bit operation |
| sleep_n | input | 1 | Active-low sleep; 0 clears the word and the output clock |
| line_fault | input | 1 | 1 = input not valid; holds the word and stops the output clock |
| word_out | output | 28 | Reassembled parallel word |
| word_clk_out | output | 1 | Output word clock; rises while word_out is stable |

## Verification
Each finished period reaches word_out 14 bit-clock cycles after its slot 0 sample, on the edge that samples slot 6 of the period after it. The directed checks therefore sample one nanosecond after the edge that takes that slot, and they look once before it and once after it. Sleep and line-fault take effect in the cycle after they are driven. Lock needs the third in-time rising step, so the first new word after a reset, a glitch, a sleep or a fault appears on the slot-6 edge of the period that follows that step. The reference model in the bench moves one slot per clock and compares both outputs at every falling edge.

// File: rtl/pixdeser_pkg.sv
package pixdeser_pkg;

    // Slots per lane in one word period.
    localparam int SLOTS       = 7;
    localparam int SLOT_W      = $clog2(SLOTS);
    // In-time rising steps needed before lock.
    localparam int STREAK_NEED = 3;
    localparam int STREAK_W    = $clog2(STREAK_NEED + 1);
    // Slots where the output clock is high.
    localparam int CLK_HI_FIRST = 2;
    localparam int CLK_HI_LAST  = 5;

    typedef logic [SLOT_W-1:0]   slot_t;
    typedef logic [STREAK_W-1:0] streak_t;

    typedef struct packed {
        slot_t slot;       // slot index of the sample in this cycle
        logic  group_end;  // this cycle carries the last slot of a period
        logic  locked;     // alignment qualified (registered)
    } frame_info_t;

    function automatic slot_t next_slot(slot_t s);
        return (s == slot_t'(SLOTS - 1)) ? '0 : s + slot_t'(1);
    endfunction

    function automatic logic in_clk_high(slot_t s);
        return (s >= slot_t'(CLK_HI_FIRST)) && (s <= slot_t'(CLK_HI_LAST));
    endfunction

endpackage

// File: rtl/pixdeser_frame_align.sv
module pixdeser_frame_align
    import pixdeser_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clk_lane,
    input  logic        link_ok,
    output frame_info_t info
);

    logic    prev_q;
    slot_t   last_q;
    streak_t streak_q;

    logic    step_seen;
    logic    on_time;
    slot_t   slot_now;

    assign step_seen = clk_lane & ~prev_q;
    assign on_time   = (last_q == slot_t'(SLOTS - 1));
    assign slot_now  = step_seen ? '0 : next_slot(last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            last_q   <= '0;
            streak_q <= '0;
        end else begin
            prev_q <= clk_lane;
            last_q <= slot_now;
            if (!link_ok) begin
                streak_q <= '0;
            end else if (step_seen) begin
                if (!on_time)
                    streak_q <= streak_t'(1);
                else if (streak_q != streak_t'(STREAK_NEED))
                    streak_q <= streak_q + streak_t'(1);
            end else if (on_time) begin
                streak_q <= '0;
            end
        end
    end

    assign info.slot      = slot_now;
    assign info.group_end = (slot_now == slot_t'(SLOTS - 1));
    assign info.locked    = (streak_q == streak_t'(STREAK_NEED));

endmodule

// File: rtl/pixdeser_lane_shift.sv
module pixdeser_lane_shift
    import pixdeser_pkg::*;
#(
    parameter int DEPTH = SLOTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    output logic [DEPTH-1:0] group
);

    logic [DEPTH-2:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[DEPTH-3:0], ser_in};
    end

    // The oldest sample (slot 0) ends up in the top bit.
    assign group = {hist_q, ser_in};

endmodule

// File: rtl/pixdeser_word_stage.sv
module pixdeser_word_stage
    import pixdeser_pkg::*;
#(
    parameter int LANES        = 4,
    parameter int NARROW_LANES = 3,
    localparam int WORD_W      = LANES * SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] groups,
    input  frame_info_t       info,
    input  logic              narrow_mode,
    input  logic              sleep_n,
    input  logic              line_fault,
    output logic [WORD_W-1:0] word_out,
    output logic              word_clk_out
);

    logic [WORD_W-1:0] captured;
    logic [WORD_W-1:0] stage_q;
    logic [WORD_W-1:0] word_q;
    logic              wclk_q;

    for (genvar k = 0; k < LANES; k++) begin : g_field
        if (k >= NARROW_LANES) begin : g_maskable
            assign captured[k*SLOTS +: SLOTS] =
                narrow_mode ? '0 : groups[k*SLOTS +: SLOTS];
        end else begin : g_always
            assign captured[k*SLOTS +: SLOTS] = groups[k*SLOTS +: SLOTS];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            word_q  <= '0;
            wclk_q  <= 1'b0;
        end else begin
            if (info.group_end)
                stage_q <= captured;
            if (!sleep_n)
                word_q <= '0;
            else if (!line_fault && info.group_end && info.locked)
                word_q <= stage_q;
            wclk_q <= sleep_n & ~line_fault & info.locked & in_clk_high(info.slot);
        end
    end

    assign word_out     = word_q;
    assign word_clk_out = wclk_q;

endmodule

// File: rtl/pixdeser_top.sv
module pixdeser_top
    import pixdeser_pkg::*;
#(
    parameter int LANES        = 4,
    parameter int NARROW_LANES = 3,
    localparam int WORD_W      = LANES * SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  lane_in,
    input  logic              clk_lane_in,
    input  logic              narrow_mode,
    input  logic              sleep_n,
    input  logic              line_fault,
    output logic [WORD_W-1:0] word_out,
    output logic              word_clk_out
);

    frame_info_t       frame_info;
    logic [WORD_W-1:0] lane_groups;

    pixdeser_frame_align u_align (
        .clk      (clk),
        .rst      (rst),
        .clk_lane (clk_lane_in),
        .link_ok  (sleep_n & ~line_fault),
        .info     (frame_info)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        pixdeser_lane_shift #(.DEPTH(SLOTS)) u_shift (
            .clk    (clk),
            .rst    (rst),
            .ser_in (lane_in[k]),
            .group  (lane_groups[k*SLOTS +: SLOTS])
        );
    end

    pixdeser_word_stage #(
        .LANES        (LANES),
        .NARROW_LANES (NARROW_LANES)
    ) u_stage (
        .clk          (clk),
        .rst          (rst),
        .groups       (lane_groups),
        .info         (frame_info),
        .narrow_mode  (narrow_mode),
        .sleep_n      (sleep_n),
        .line_fault   (line_fault),
        .word_out     (word_out),
        .word_clk_out (word_clk_out)
    );

endmodule

// File: rtl/pixdeser_checks.sv
module pixdeser_checks #(
    parameter int WORD_W = 28
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep_n,
    input logic              line_fault,
    input logic              locked,
    input logic              word_clk_out,
    input logic [WORD_W-1:0] word_out
);

    logic [2:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)               hi_run <= '0;
        else if (!word_clk_out) hi_run <= '0;
        else if (hi_run != 3'd7) hi_run <= hi_run + 3'd1;
    end

    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (word_out == '0) && !word_clk_out);

    a_r9_sleep_clears: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |=> (word_out == '0) && !word_clk_out);

    a_r10_fault_holds: assert property (@(posedge clk) disable iff (rst)
        (sleep_n && line_fault) |=> $stable(word_out) && !word_clk_out);

    a_r5_clk_needs_lock: assert property (@(posedge clk) disable iff (rst)
        word_clk_out |-> $past(locked));

    a_r5_update_needs_lock: assert property (@(posedge clk) disable iff (rst)
        ($past(sleep_n) && !$stable(word_out)) |-> $past(locked));

    a_r8_clk_high_len: assert property (@(posedge clk) disable iff (rst)
        word_clk_out |-> (hi_run < 3'd4));

    a_r7_change_clk_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(word_out) |-> !word_clk_out);

endmodule

bind pixdeser_top pixdeser_checks #(.WORD_W(WORD_W)) u_checks (
    .clk          (clk),
    .rst          (rst),
    .sleep_n      (sleep_n),
    .line_fault   (line_fault),
    .locked       (frame_info.locked),
    .word_clk_out (word_clk_out),
    .word_out     (word_out)
);

// File: tb/pixdeser_top_bench.sv
`timescale 1ns/1ps
module pixdeser_top_bench;

    localparam int LN = 4;
    localparam int SL = 7;
    localparam int W  = LN * SL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [LN-1:0] lane_in = '0;
    logic          clk_lane = 1'b0;
    logic          narrow = 1'b0;
    logic          sleep_n = 1'b1;
    logic          line_fault = 1'b0;
    logic [W-1:0]  word_out;
    logic          word_clk_out;

    always #2.5 clk = ~clk;

    pixdeser_top u_pixdeser_top (
        .clk          (clk),
        .rst          (rst),
        .lane_in      (lane_in),
        .clk_lane_in  (clk_lane),
        .narrow_mode  (narrow),
        .sleep_n      (sleep_n),
        .line_fault   (line_fault),
        .word_out     (word_out),
        .word_clk_out (word_clk_out)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // Behavioural reference model, one slot per clock.
    int          m_prev, m_ph, m_run, m_nx;
    bit          m_step, m_lk, m_ck;
    logic [6:0]  m_acc [LN];
    logic [W-1:0] m_out, m_stage, m_cap;
    string       m_tag = "R11";

    always @(posedge clk) begin
        if (rst) begin
            m_prev = 0; m_ph = 0; m_run = 0; m_ck = 0;
            m_out = '0; m_stage = '0; m_tag = "R11";
            for (int k = 0; k < LN; k++) m_acc[k] = '0;
        end else begin
            m_step = (m_prev == 0) && (clk_lane == 1'b1);
            m_nx   = m_step ? 0 : (m_ph + 1) % SL;
            m_lk   = (m_run >= 3);
            for (int k = 0; k < LN; k++) begin
                m_acc[k] = {m_acc[k][5:0], lane_in[k]};
                m_cap[k*SL +: SL] = (narrow && k == 3) ? 7'd0 : m_acc[k];
            end
            if (!sleep_n) m_out = '0;
            else if (!line_fault && m_nx == 6 && m_lk) m_out = m_stage;
            if (m_nx == 6) m_stage = m_cap;
            m_ck = sleep_n && !line_fault && m_lk && m_nx >= 2 && m_nx <= 5;
            if (!sleep_n || line_fault) m_run = 0;
            else if (m_step) m_run = (m_ph == 6) ? ((m_run < 3) ? m_run + 1 : 3) : 1;
            else if (m_ph == 6) m_run = 0;
            m_tag = !sleep_n ? "R9" : line_fault ? "R10" : !m_lk ? "R5" : "R7";
            m_ph = m_nx;
            m_prev = clk_lane;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            vectors++;
            if (word_out !== m_out) begin
                fails++;
                $display("FAIL %s model word: actual %h expected %h", m_tag, word_out, m_out);
            end
            vectors++;
            if (word_clk_out !== m_ck) begin
                fails++;
                $display("FAIL R8 model word clock: actual %b expected %b", word_clk_out, m_ck);
            end
        end
    end

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic drive_slot(logic [LN-1:0] b, logic ck);
        @(negedge clk);
        lane_in  = b;
        clk_lane = ck;
    endtask

    // Sends slots from..to of word w; slot j of lane k carries w[7k+6-j].
    task automatic send_part(logic [W-1:0] w, int from, int to);
        for (int j = from; j <= to; j++) begin
            logic [LN-1:0] b;
            for (int k = 0; k < LN; k++) b[k] = w[k*SL + 6 - j];
            drive_slot(b, j < 4);
        end
    endtask

    task automatic send_frame(logic [W-1:0] w);
        send_part(w, 0, 6);
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    localparam logic [W-1:0] D0  = 28'h1234567;
    localparam logic [W-1:0] D1  = 28'hA5C3E17;
    localparam logic [W-1:0] D2  = 28'h0204081;
    localparam logic [W-1:0] D3  = 28'h8102040;
    localparam logic [W-1:0] D4  = 28'h5F0A3C9;
    localparam logic [W-1:0] D5  = 28'h0FEDCBA;
    localparam logic [W-1:0] D6  = 28'hFE6B2D1;
    localparam logic [W-1:0] D7  = 28'hFFFFFFF;
    localparam logic [W-1:0] NMASK = 28'h01FFFFF;

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();
        check("R11 reset word", word_out, '0);
        check("R11 reset clock", {27'd0, word_clk_out}, '0);

        // R4: three idle slots first, so the period start comes only from the step.
        repeat (3) drive_slot('0, 1'b0);
        send_frame(D0);
        send_frame(D1);
        settle();
        check("R5 no word before lock", word_out, '0);
        send_frame(D2);
        settle();
        check("R4 first word aligned to rising step", word_out, D1);
        send_frame(D3);
        settle();
        check("R1 slot6 to bit 7k", word_out, D2);
        send_part(D4, 0, 5);
        settle();
        check("R7 no change before slot6 edge", word_out, D2);
        send_part(D4, 6, 6);
        settle();
        check("R1 slot0 to bit 7k+6 at latency 14 R7", word_out, D3);
        check("R8 clock low at change", {27'd0, word_clk_out}, '0);

        for (int j = 0; j < SL; j++) begin
            send_part(D5, j, j);
            settle();
            check("R8 clock shape", {27'd0, word_clk_out},
                  {27'd0, (j >= 2 && j <= 5)});
        end
        check("R2 wide word", word_out, D4);

        // R3: narrow mode masks lane 3.
        narrow = 1'b1;
        send_frame(D6);
        send_frame(D7);
        settle();
        check("R3 narrow top bits zero", word_out, D6 & NMASK);
        narrow = 1'b0;

        // R6: three stray slots shift the period start.
        send_part(D0, 4, 6);
        send_frame(D1);
        send_frame(D2);
        settle();
        check("R6 held while relocking", word_out, D6 & NMASK);
        send_frame(D3);
        settle();
        check("R6 word after relock", word_out, D2);

        // R9: sleep.
        sleep_n = 1'b0;
        send_frame(D4);
        settle();
        check("R9 sleep word zero", word_out, '0);
        check("R9 sleep clock low", {27'd0, word_clk_out}, '0);
        sleep_n = 1'b1;
        send_frame(D5);
        send_frame(D6);
        settle();
        check("R9 zero until relock", word_out, '0);
        send_frame(D0);
        send_frame(D1);
        settle();
        check("R9 word after wake", word_out, D0);

        // R10: line fault.
        line_fault = 1'b1;
        send_frame(D2);
        settle();
        check("R10 fault holds word", word_out, D0);
        check("R10 fault clock low", {27'd0, word_clk_out}, '0);
        line_fault = 1'b0;
        send_frame(D3);
        send_frame(D4);
        settle();
        check("R10 held until relock", word_out, D0);
        send_frame(D5);
        send_frame(D6);
        settle();
        check("R10 word after fault", word_out, D5);

        repeat (4) drive_slot('0, 1'b0);
        report();
    end

endmodule